// File: doc/BRIEF.md
# DMA Channel Control and Status Register Bank

This block sits next to a SCSI controller core and gives software a small bank of four 32-bit word registers to steer that core's DMA channel. Word 0 is the channel control and status word. Word 1 holds the DMA start address. Words 2 and 3 are plain scratch storage. Byte address bits [3:2] pick the word for both reads and writes. Reads are combinational and change nothing.

A write to the control word does not simply store the value. A fixed chain of rules is applied first:
- A set bit 7 issues a reset to the SCSI core and clears words 1 to 3.
- Otherwise, a set bit 6 is dropped.
- Otherwise, an all-zero value is turned into 0x40.
- Bits 31:28 always read back the version code 0xA.

Loading the address word also rewrites the control word to the address-loaded flag, bit 26, and nothing else.

When the core reports a finished operation, bit 0 (interrupt pending) is set. The interrupt line is raised while bit 0 and bit 4 (interrupt enable) are both set. A two-state sequencer holds the core reset output for a fixed number of cycles:
- `RS_IDLE` goes to `RS_HOLD` on a reset command.
- `RS_HOLD` stays in `RS_HOLD` while cycles remain, and reloads its count on a repeated command.
- `RS_HOLD` returns to `RS_IDLE` when the count expires.

Top module: `dma_ctl_regs`

## Requirements
- R1: After reset, all four words read zero, and irq_o and core_rst_o are low.
- R2: Address bits [3:2] select the word, with 0=control, 1=address, 2 and 3=scratch. rdata shows the selected word in the same cycle. A read has no side effect, and words 2 and 3 store any value written.
- R3: A control write with bit 7 clear and bit 6 set stores the value with bit 6 cleared. Every control write stores 0xA in bits 31:28.
- R4: A control write with bit 7 set has these effects:
  - core_rst_o is high for exactly RST_LEN cycles, starting in the cycle after the write.
  - Words 1 to 3 become zero.
  - The control word becomes (value AND 0x0FFFFFFF) OR 0xA0000000, with bit 6 kept.
  - A further such write while core_rst_o is high restarts the RST_LEN-cycle window.
- R5: A control write of 0x00000000 stores 0xA0000040.
- R6: Any other control write (bits 7 and 6 clear, value nonzero) stores the value with bits 31:28 replaced by 0xA.
- R7: A write to the address word stores the value there and sets the control word to 0x04000000.
- R8: irq_o is high exactly when control bit 0 and control bit 4 are both set. A control write with bit 4 clear leaves irq_o low in the following cycle.
- R9: A core_done pulse sets control bit 0 at the next edge. The bit stays set until a control or address write replaces it.
- R10: core_done in the same cycle as a control write (bit 7 clear) or an address write sets bit 0 on top of the written result.
- R11: core_done is ignored while core_rst_o is high, and in the cycle of a control write with bit 7 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the word at addr |
| addr | input | ADDR_W | Byte address; bits [3:2] pick the word |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Selected word, combinational |
| core_done | input | 1 | Completion pulse from the SCSI core |
| core_rst_o | output | 1 | Reset to the SCSI core |
| irq_o | output | 1 | Gated interrupt request |

## Verification
The same-cycle case is core_done arriving in the cycle of a register write. The bench provokes it three ways:
- with a plain control write, where bit 0 must end set;
- with an address load, where the control word must read 0x04000001;
- with a reset command, where bit 0 must stay clear and the pulse is ignored.

It also raises core_done inside the reset window, where the pulse must be dropped. A behavioural model kept in integers is compared against the outputs every cycle, alongside directed checks against literal values.

// File: rtl/dma_ctl_pkg.sv
package dma_ctl_pkg;
    localparam int DATA_W      = 32;
    localparam int NUM_REGS    = 4;
    localparam int IDX_W       = $clog2(NUM_REGS);
    localparam int VER_HI      = 31;
    localparam int VER_LO      = 28;
    localparam logic [3:0] VERSION_CODE = 4'hA;
    localparam int LOADED_BIT  = 26;
    localparam int RST_CMD_BIT = 7;
    localparam int SELFCLR_BIT = 6;
    localparam int IEN_BIT     = 4;
    localparam int PEND_BIT    = 0;
    localparam logic [DATA_W-1:0] ZERO_SUBST = 32'h0000_0040;

    localparam logic [IDX_W-1:0] IDX_CTRL = IDX_W'(0);
    localparam logic [IDX_W-1:0] IDX_ADDR = IDX_W'(1);

    typedef enum logic [0:0] {
        RS_IDLE = 1'b0,
        RS_HOLD = 1'b1
    } rst_state_t;
endpackage

// File: rtl/dma_ctl_decode.sv
module dma_ctl_decode
    import dma_ctl_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx,
    output logic [NUM_REGS-1:0] wr_sel
);
    assign idx = addr[IDX_W+1:2];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_sel
        assign wr_sel[g] = wr_en && (idx == IDX_W'(g));
    end
endmodule

// File: rtl/dma_ctl_ctrl_rule.sv
module dma_ctl_ctrl_rule
    import dma_ctl_pkg::*;
(
    input  logic [DATA_W-1:0] wdata,
    output logic              reset_cmd,
    output logic [DATA_W-1:0] ctrl_value
);
    logic [DATA_W-1:0] shaped;

    assign reset_cmd = wdata[RST_CMD_BIT];

    always_comb begin
        shaped = wdata;
        if (wdata[RST_CMD_BIT]) begin
            shaped = wdata;
        end else if (wdata[SELFCLR_BIT]) begin
            shaped[SELFCLR_BIT] = 1'b0;
        end else if (wdata == '0) begin
            shaped = ZERO_SUBST;
        end
        ctrl_value = shaped;
        ctrl_value[VER_HI:VER_LO] = VERSION_CODE;
    end
endmodule

// File: rtl/dma_ctl_rst_seq.sv
module dma_ctl_rst_seq
    import dma_ctl_pkg::*;
#(
    parameter int RST_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trigger,
    output logic hold
);
    localparam int CNT_W = $clog2(RST_LEN + 1);
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(RST_LEN - 1);

    rst_state_t state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RS_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            RS_IDLE: begin
                if (trigger) begin
                    state_d = RS_HOLD;
                    cnt_d   = RELOAD;
                end
            end
            RS_HOLD: begin
                if (trigger) begin
                    cnt_d = RELOAD;
                end else if (cnt_q == '0) begin
                    state_d = RS_IDLE;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: state_d = RS_IDLE;
        endcase
    end

    always_comb begin
        unique case (state_q)
            RS_HOLD: hold = 1'b1;
            default: hold = 1'b0;
        endcase
    end
endmodule

// File: rtl/dma_ctl_regs.sv
module dma_ctl_regs
    import dma_ctl_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int RST_LEN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic              core_done,
    output logic              core_rst_o,
    output logic              irq_o
);
    logic [IDX_W-1:0]    idx;
    logic [NUM_REGS-1:0] wr_sel;
    logic                reset_cmd;
    logic [DATA_W-1:0]   ctrl_value;
    logic                hold;
    logic                reset_wr;
    logic                done_ok;
    logic [DATA_W-1:0]   word_q [NUM_REGS];
    logic [DATA_W-1:0]   ctrl_q;

    dma_ctl_decode #(.ADDR_W(ADDR_W)) u_decode (
        .wr_en  (wr_en),
        .addr   (addr),
        .idx    (idx),
        .wr_sel (wr_sel)
    );

    dma_ctl_ctrl_rule u_rule (
        .wdata      (wdata),
        .reset_cmd  (reset_cmd),
        .ctrl_value (ctrl_value)
    );

    assign reset_wr = wr_sel[IDX_CTRL] && reset_cmd;
    assign done_ok  = core_done && !hold && !reset_wr;

    dma_ctl_rst_seq #(.RST_LEN(RST_LEN)) u_rst_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .trigger (reset_wr),
        .hold    (hold)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) word_q[i] <= '0;
        end else begin
            for (int i = 0; i < NUM_REGS; i++) begin
                if (i == int'(IDX_CTRL)) begin
                    if (wr_sel[IDX_CTRL])
                        word_q[i] <= ctrl_value | {{(DATA_W-1){1'b0}}, done_ok};
                    else if (wr_sel[IDX_ADDR])
                        word_q[i] <= (DATA_W'(1) << LOADED_BIT) | {{(DATA_W-1){1'b0}}, done_ok};
                    else if (done_ok)
                        word_q[i][PEND_BIT] <= 1'b1;
                end else if (reset_wr) begin
                    word_q[i] <= '0;
                end else if (wr_sel[i]) begin
                    word_q[i] <= wdata;
                end
            end
        end
    end

    assign ctrl_q     = word_q[IDX_CTRL];
    assign rdata      = word_q[idx];
    assign core_rst_o = hold;
    assign irq_o      = ctrl_q[PEND_BIT] && ctrl_q[IEN_BIT];
endmodule

// File: rtl/dma_ctl_regs_chk.sv
module dma_ctl_regs_chk #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [31:0]       wdata,
    input logic              core_done,
    input logic              core_rst_o,
    input logic              irq_o,
    input logic [31:0]       ctrl_q
);
    logic sel0, sel1;
    assign sel0 = wr_en && (addr[3:2] == 2'd0);
    assign sel1 = wr_en && (addr[3:2] == 2'd1);

    assert_rst_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel0 && wdata[7]) |=> core_rst_o);

    assert_version_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sel0 |=> (ctrl_q[31:28] == 4'hA));

    assert_selfclr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sel0 && !wdata[7] && wdata[6]) |=> !ctrl_q[6]);

    assert_zero_subst_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel0 && (wdata == 32'h0) && !core_done) |=> (ctrl_q == 32'hA000_0040));

    assert_addr_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sel1 && !core_done) |=> (ctrl_q == 32'h0400_0000));

    assert_irq_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sel0 && !wdata[4]) |=> !irq_o);

    assert_done_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (core_done && !core_rst_o && !(sel0 && wdata[7])) |=> ctrl_q[0]);

    assert_done_masked_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (core_rst_o && core_done && !wr_en && !ctrl_q[0]) |=> !ctrl_q[0]);
endmodule

bind dma_ctl_regs dma_ctl_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .addr       (addr),
    .wdata      (wdata),
    .core_done  (core_done),
    .core_rst_o (core_rst_o),
    .irq_o      (irq_o),
    .ctrl_q     (ctrl_q)
);

// File: tb/dma_ctl_regs_bench.sv
`timescale 1ns/1ps
module dma_ctl_regs_bench;
    localparam int RST_LEN = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        core_done = 1'b0;
    logic [31:0] rdata;
    logic        core_rst_o;
    logic        irq_o;

    int total = 0;
    int bad = 0;
    string cur_tag = "R1";

    logic [31:0] m_reg [4] = '{default: 32'h0};
    int          m_hold = 0;

    always #2 clk = ~clk;

    dma_ctl_regs #(.ADDR_W(4), .RST_LEN(RST_LEN)) u_dma_ctl_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .core_done(core_done), .core_rst_o(core_rst_o), .irq_o(irq_o)
    );

    // behavioural reference model
    always @(posedge clk) begin
        logic        rst_wr;
        logic        done_ok;
        logic [31:0] v;
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) m_reg[i] = 32'h0;
            m_hold = 0;
        end else begin
            rst_wr  = wr_en && (addr[3:2] == 2'd0) && wdata[7];
            done_ok = core_done && (m_hold == 0) && !rst_wr;
            if (rst_wr) m_hold = RST_LEN;
            else if (m_hold > 0) m_hold = m_hold - 1;
            if (wr_en) begin
                case (addr[3:2])
                    2'd0: begin
                        if (wdata[7]) begin
                            v = wdata;
                            for (int i = 1; i < 4; i++) m_reg[i] = 32'h0;
                        end else if (wdata[6]) v = wdata & ~32'h40;
                        else if (wdata == 0) v = 32'h40;
                        else v = wdata;
                        m_reg[0] = (v & 32'h0FFF_FFFF) | 32'hA000_0000;
                    end
                    2'd1: begin
                        m_reg[1] = wdata;
                        m_reg[0] = 32'h0400_0000;
                    end
                    default: m_reg[addr[3:2]] = wdata;
                endcase
            end
            if (done_ok) m_reg[0] = m_reg[0] | 32'h1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            chk(cur_tag, rdata, m_reg[addr[3:2]]);
            chk("R8", {31'b0, irq_o}, {31'b0, m_reg[0][0] & m_reg[0][4]});
            chk("R4", {31'b0, core_rst_o}, {31'b0, m_hold > 0});
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic done);
        @(posedge clk); #1;
        wr_en = 1'b1; addr = a; wdata = d; core_done = done;
        @(posedge clk); #1;
        wr_en = 1'b0; core_done = 1'b0;
    endtask

    task automatic pulse_done();
        @(posedge clk); #1; core_done = 1'b1;
        @(posedge clk); #1; core_done = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
        @(posedge clk); #1; addr = a;
        @(negedge clk);
        chk(tag, rdata, exp);
    endtask

    initial begin
        #(200000 * 4);
        bad++; total++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int cnt;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        for (int i = 0; i < 4; i++) rd(4'(i * 4), 32'h0, "R1");
        chk("R1", {30'b0, irq_o, core_rst_o}, 32'h0);

        cur_tag = "R2";
        wr(4'h8, 32'h1234_5678, 1'b0);
        wr(4'hC, 32'hCAFE_F00D, 1'b0);
        rd(4'h8, 32'h1234_5678, "R2");
        rd(4'h8, 32'h1234_5678, "R2");
        rd(4'hD, 32'hCAFE_F00D, "R2");

        cur_tag = "R6";
        wr(4'h0, 32'h0000_0011, 1'b0);
        rd(4'h0, 32'hA000_0011, "R6");
        chk("R8", {31'b0, irq_o}, 32'h1);
        wr(4'h0, 32'h3000_0001, 1'b0);
        rd(4'h0, 32'hA000_0001, "R8");
        chk("R8", {31'b0, irq_o}, 32'h0);

        cur_tag = "R3";
        wr(4'h0, 32'h5000_0050, 1'b0);
        rd(4'h0, 32'hA000_0010, "R3");

        cur_tag = "R5";
        wr(4'h0, 32'h0, 1'b0);
        rd(4'h0, 32'hA000_0040, "R5");

        cur_tag = "R7";
        wr(4'h4, 32'hDEAD_BEE0, 1'b0);
        rd(4'h4, 32'hDEAD_BEE0, "R7");
        rd(4'h0, 32'h0400_0000, "R7");

        cur_tag = "R9";
        pulse_done();
        rd(4'h0, 32'h0400_0001, "R9");
        wr(4'h0, 32'h0000_0010, 1'b0);
        chk("R9", {31'b0, irq_o}, 32'h0);
        pulse_done();
        rd(4'h0, 32'hA000_0011, "R9");
        chk("R9", {31'b0, irq_o}, 32'h1);

        cur_tag = "R10";
        wr(4'h0, 32'h0000_0030, 1'b1);
        rd(4'h0, 32'hA000_0031, "R10");
        wr(4'h4, 32'h0000_1000, 1'b1);
        rd(4'h0, 32'h0400_0001, "R10");

        cur_tag = "R4";
        wr(4'h8, 32'h5555_AAAA, 1'b0);
        wr(4'h0, 32'hF000_00D0, 1'b1);
        cnt = 0;
        for (int i = 0; i < RST_LEN + 4; i++) begin
            @(negedge clk);
            if (core_rst_o) cnt++;
        end
        chk("R4", cnt, RST_LEN);
        rd(4'h0, 32'hA000_00D0, "R11");
        rd(4'h4, 32'h0, "R4");
        rd(4'h8, 32'h0, "R4");

        cur_tag = "R11";
        wr(4'h0, 32'h0000_0090, 1'b0);
        pulse_done();
        pulse_done();
        rd(4'h0, 32'hA000_0090, "R11");

        // retrigger inside the window
        repeat (RST_LEN + 2) @(posedge clk);
        cur_tag = "R4";
        wr(4'h0, 32'h0000_0080, 1'b0);
        wr(4'h0, 32'h0000_0080, 1'b0);
        cnt = 0;
        for (int i = 0; i < RST_LEN + 6; i++) begin
            @(negedge clk);
            if (core_rst_o) cnt++;
        end
        chk("R4", cnt, RST_LEN);

        repeat (2) @(posedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule